// File: doc/BRIEF.md
# Resistive Touch Position Sampler

This block polls a resistive touch-panel converter over a four-wire SPI link in mode 0 (clock idles low, data launched on the falling edge and captured on the rising edge). One measurement batch reads the horizontal channel several times and then the vertical channel several times. Each axis's readings are averaged to suppress panel noise. A per-axis gain and offset then map the averaged raw counts onto a 480 by 320 pixel display frame.

The result is a pixel coordinate pair, announced by a single-cycle strobe. The gain and offset for each axis are plain configuration inputs. Polling runs while the enable input is high. A batch that has already started always finishes, so a coordinate pair is never built from a partial set of readings. With the default divider, a 50 MHz system clock gives a 1 MHz serial clock.

Top module: `touch_coord_sampler`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0 and `coord_valid` is 0. The serial clock is low whenever chip select is high.
- R2: A transaction holds `spi_cs_n` low for exactly 24 rising edges of `spi_sclk`. During the first 8 rising edges the command byte is sent MSB first on `spi_mosi`: 8'hD0 selects the X channel and 8'h90 selects the Y channel.
- R3: Between two transactions `spi_cs_n` stays high for at least one serial clock period (2*SCLK_HALF system clocks).
- R4: The raw reading is the 12 bits sampled on `spi_miso` at rising edges 9 to 20 of a transaction, MSB first. The bits sampled at edges 21 to 24 do not affect the result.
- R5: A batch is 2^AVG_LOG2 X transactions followed by 2^AVG_LOG2 Y transactions (8 each by default). Exactly one `coord_valid` pulse follows each batch.
- R6: The averaged value of an axis is the sum of its readings shifted right by AVG_LOG2 (floor of the mean).
- R7: The corrected value is ((avg * gain) >> 16) + offset. `gain_*` is an unsigned value with 16 fraction bits, and `offset_*` is a signed two's-complement value.
- R8: A corrected value below 0 gives 0. A value above 479 (X) or 319 (Y) gives 479 or 319 respectively.
- R9: While `sample_en` is low and no batch is in progress, no transaction starts. Lowering `sample_en` in the middle of a batch lets that batch complete and deliver its coordinates.
- R10: `coord_valid` is high for exactly one clock per batch. `coord_x` and `coord_y` change only in the cycle in which `coord_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Allows new measurement batches to start |
| gain_x | input | GAIN_W | X gain, 16 fraction bits |
| offset_x | input | OFF_W | X offset in pixels, signed |
| gain_y | input | GAIN_W | Y gain, 16 fraction bits |
| offset_y | input | OFF_W | Y offset in pixels, signed |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Command data to converter |
| spi_miso | input | 1 | Conversion data from converter |
| coord_x | output | $clog2(DISP_W) | Corrected X pixel |
| coord_y | output | $clog2(DISP_H) | Corrected Y pixel |
| coord_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
Two situations are hard to reach from the ports.

The first is dropping the enable partway through a batch. The bench polls its own count of finished X transactions and lowers `sample_en` after the third one. It then expects the full batch and its coordinates, followed by silence on the bus.

The second is the clamping corners, which need readings that land outside the frame. A bench model of the converter decodes each command byte and returns per-read values that alternate between two levels, with a junk trailing nibble. Gain and offset settings are chosen so that the average hits floor rounding and is pushed below zero or past the frame edge.

// File: rtl/touch_coord_sampler.sv
module touch_coord_sampler #(
  parameter int          SCLK_HALF = 25,
  parameter int          AVG_LOG2  = 3,
  parameter int          GAIN_W    = 18,
  parameter int          OFF_W     = 12,
  parameter int          DISP_W    = 480,
  parameter int          DISP_H    = 320,
  parameter logic [7:0]  CMD_X     = 8'hD0,
  parameter logic [7:0]  CMD_Y     = 8'h90,
  localparam int         CX_W      = $clog2(DISP_W),
  localparam int         CY_W      = $clog2(DISP_H)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_en,
  input  logic [GAIN_W-1:0]       gain_x,
  input  logic signed [OFF_W-1:0] offset_x,
  input  logic [GAIN_W-1:0]       gain_y,
  input  logic signed [OFF_W-1:0] offset_y,
  output logic                    spi_sclk,
  output logic                    spi_cs_n,
  output logic                    spi_mosi,
  input  logic                    spi_miso,
  output logic [CX_W-1:0]         coord_x,
  output logic [CY_W-1:0]         coord_y,
  output logic                    coord_valid
);

  localparam int ACC_W    = 12 + AVG_LOG2;
  localparam int PROD_W   = 12 + GAIN_W;
  localparam int SCL_W    = PROD_W - 16;
  localparam int SUM_W    = ((SCL_W > OFF_W) ? SCL_W : OFF_W) + 2;
  localparam int GAP_CLKS = 2 * SCLK_HALF;
  localparam int DIV_W    = $clog2(GAP_CLKS + 1);
  localparam int IDX_W    = AVG_LOG2 + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_DONE} state_t;

  state_t             state;
  logic [DIV_W-1:0]   div_cnt;
  logic [4:0]         fall_cnt;
  logic [7:0]         tx_sr;
  logic [15:0]        rx_sr;
  logic [IDX_W-1:0]   rd_idx;
  logic [ACC_W-1:0]   acc_x, acc_y;

  wire        axis_y   = rd_idx[AVG_LOG2];
  wire        half_end = (div_cnt == DIV_W'(SCLK_HALF - 1));
  wire [11:0] raw      = rx_sr[15:4];

  assign spi_mosi = tx_sr[7];

  wire [11:0] avg_x = acc_x[ACC_W-1:AVG_LOG2];
  wire [11:0] avg_y = acc_y[ACC_W-1:AVG_LOG2];

  logic [PROD_W-1:0] prod_x, prod_y;
  assign prod_x = {{GAIN_W{1'b0}}, avg_x} * {12'b0, gain_x};
  assign prod_y = {{GAIN_W{1'b0}}, avg_y} * {12'b0, gain_y};

  logic signed [SUM_W-1:0] sum_x, sum_y;
  assign sum_x = $signed({{(SUM_W-SCL_W){1'b0}}, prod_x[PROD_W-1:16]})
               + $signed({{(SUM_W-OFF_W){offset_x[OFF_W-1]}}, offset_x});
  assign sum_y = $signed({{(SUM_W-SCL_W){1'b0}}, prod_y[PROD_W-1:16]})
               + $signed({{(SUM_W-OFF_W){offset_y[OFF_W-1]}}, offset_y});

  function automatic logic [15:0] clamp_px(input logic signed [SUM_W-1:0] v, input int lim);
    logic signed [SUM_W-1:0] top;
    top = $signed(SUM_W'(lim - 1));
    if (v < 0)        return 16'd0;
    else if (v > top) return 16'(top);
    else              return 16'(v);
  endfunction

  logic [15:0] cx_full, cy_full;
  assign cx_full = clamp_px(sum_x, DISP_W);
  assign cy_full = clamp_px(sum_y, DISP_H);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      div_cnt     <= '0;
      fall_cnt    <= '0;
      tx_sr       <= '0;
      rx_sr       <= '0;
      rd_idx      <= '0;
      acc_x       <= '0;
      acc_y       <= '0;
      spi_sclk    <= 1'b0;
      spi_cs_n    <= 1'b1;
      coord_x     <= '0;
      coord_y     <= '0;
      coord_valid <= 1'b0;
    end else begin
      coord_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (sample_en || rd_idx != '0) begin
            spi_cs_n <= 1'b0;
            tx_sr    <= axis_y ? CMD_Y : CMD_X;
            div_cnt  <= '0;
            fall_cnt <= '0;
            state    <= S_XFER;
          end
        end
        S_XFER: begin
          if (!half_end) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
              rx_sr    <= {rx_sr[14:0], spi_miso};
            end else begin
              spi_sclk <= 1'b0;
              tx_sr    <= {tx_sr[6:0], 1'b0};
              fall_cnt <= fall_cnt + 1'b1;
              if (fall_cnt == 5'd23) begin
                spi_cs_n <= 1'b1;
                if (axis_y) acc_y <= acc_y + ACC_W'(raw);
                else        acc_x <= acc_x + ACC_W'(raw);
                rd_idx <= rd_idx + 1'b1;
                state  <= (rd_idx == '1) ? S_DONE : S_GAP;
              end
            end
          end
        end
        S_DONE: begin
          coord_x     <= cx_full[CX_W-1:0];
          coord_y     <= cy_full[CY_W-1:0];
          coord_valid <= 1'b1;
          acc_x       <= '0;
          acc_y       <= '0;
          div_cnt     <= '0;
          state       <= S_GAP;
        end
        default: begin
          if (div_cnt == DIV_W'(GAP_CLKS - 1)) begin
            div_cnt <= '0;
            state   <= S_IDLE;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_mosi);

  p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  p_clamp_x_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coord_x <= CX_W'(DISP_W - 1));

  p_clamp_y_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coord_y <= CY_W'(DISP_H - 1));

  p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && rd_idx == '0 && !sample_en) |=> spi_cs_n);

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    coord_valid |=> !coord_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !coord_valid |-> ($stable(coord_x) && $stable(coord_y)));

endmodule

// File: tb/touch_coord_sampler_tb.sv
module touch_coord_sampler_tb;
  localparam int HALF = 2;
  localparam logic [7:0] CX = 8'hD0, CY = 8'h90;

  logic clk = 0, rst_n = 0, sample_en = 0, spi_miso = 0;
  logic [17:0] gain_x = 0, gain_y = 0;
  logic signed [11:0] offset_x = 0, offset_y = 0;
  logic spi_sclk, spi_cs_n, spi_mosi, coord_valid;
  logic [8:0] coord_x, coord_y;

  always #10 clk = ~clk;

  touch_coord_sampler #(.SCLK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .gain_x(gain_x), .offset_x(offset_x), .gain_y(gain_y), .offset_y(offset_y),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .coord_x(coord_x), .coord_y(coord_y), .coord_valid(coord_valid));

  int checks = 0, errors = 0;
  int xa, xb, ya, yb;
  int rise_cnt = 0, xtx = 0, ytx = 0, bad_len = 0, bad_cmd = 0, order_err = 0;
  int pulses = 0, wide_err = 0;
  logic [7:0] cmd;
  logic prev_valid = 0;
  realtime t_hi = 0, min_gap = 1.0e9;
  bit seen_hi = 0, done = 0;

  // xa xb ya yb gain_x off_x gain_y off_y
  localparam int VEC [5][8] = '{
    '{2048, 2048, 1024, 1024,   7680,    0, 5120,  0},
    '{ 100,  103, 4000, 3999,   7680,  -10, 5120,  5},
    '{  50,   50, 4095, 4095,   7680, -100, 65536, 0},
    '{4095, 4094,    0,    1, 131072,  100, 5120, -1},
    '{3000, 1000,  600, 2600,   8000,    7, 6000, -3}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_px(input int a, input int b, input int g, input int o, input int lim);
    longint avg, v;
    avg = (4 * a + 4 * b) / 8;
    v = ((avg * g) >>> 16) + o;
    if (v < 0) v = 0;
    if (v > lim - 1) v = lim - 1;
    return int'(v);
  endfunction

  // converter model
  initial forever begin
    @(negedge spi_cs_n);
    rise_cnt = 0; cmd = 0; spi_miso = 0;
  end
  initial forever begin
    @(posedge spi_sclk);
    if (rise_cnt < 8) cmd = {cmd[6:0], spi_mosi};
    rise_cnt++;
  end
  initial forever begin
    logic [15:0] word;
    int v;
    @(negedge spi_sclk);
    v = (cmd == CX) ? (xtx[0] ? xb : xa) : (ytx[0] ? yb : ya);
    word = {v[11:0], 4'hA};
    if (rise_cnt >= 8 && rise_cnt <= 23) spi_miso = word[23 - rise_cnt];
    else spi_miso = 0;
  end
  initial forever begin
    @(posedge spi_cs_n);
    if (rst_n) begin
      if (rise_cnt != 24) bad_len++;
      if (cmd == CX) begin
        if (ytx > 0) order_err++;
        xtx++;
      end else if (cmd == CY) ytx++;
      else bad_cmd++;
      t_hi = $realtime; seen_hi = 1;
    end
  end
  initial forever begin
    @(negedge spi_cs_n);
    if (seen_hi && ($realtime - t_hi) < min_gap) min_gap = $realtime - t_hi;
  end
  initial forever begin
    @(negedge clk);
    if (coord_valid) pulses++;
    if (coord_valid && prev_valid) wide_err++;
    prev_valid = coord_valid;
  end

  task automatic clear_counts();
    xtx = 0; ytx = 0; bad_len = 0; bad_cmd = 0; order_err = 0; pulses = 0;
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (coord_valid) begin ok = 1; break; end
    end
    if (!ok) begin
      checks++; errors++;
      $display("FAIL R5 actual=no coord_valid expected=coord_valid pulse");
    end
  endtask

  task automatic load_vec(input int i);
    xa = VEC[i][0]; xb = VEC[i][1]; ya = VEC[i][2]; yb = VEC[i][3];
    gain_x = 18'(VEC[i][4]); offset_x = 12'(VEC[i][5]);
    gain_y = 18'(VEC[i][6]); offset_y = 12'(VEC[i][7]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int hx, hy;
    repeat (3) @(negedge clk);
    chk("R1 cs_n reset", int'(spi_cs_n), 1);
    chk("R1 sclk reset", int'(spi_sclk), 0);
    chk("R1 valid reset", int'(coord_valid), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      load_vec(i);
      clear_counts();
      sample_en = 1;
      wait_valid(ok);
      sample_en = 0;
      // R4 R6 R7 R8: averaged, corrected, clamped, trailing nibble ignored
      chk("R7 coord_x", int'(coord_x), expect_px(xa, xb, VEC[i][4], VEC[i][5], 480));
      chk("R7 coord_y", int'(coord_y), expect_px(ya, yb, VEC[i][6], VEC[i][7], 320));
      chk("R5 x reads", xtx, 8);
      chk("R5 y reads", ytx, 8);
      chk("R5 order", order_err, 0);
      chk("R2 length", bad_len, 0);
      chk("R2 command", bad_cmd, 0);
      repeat (20) @(negedge clk);
    end

    // R9 idle with enable low, R10 hold
    hx = coord_x; hy = coord_y;
    clear_counts();
    repeat (400) @(negedge clk);
    chk("R9 no transactions", xtx + ytx, 0);
    chk("R10 no pulse", pulses, 0);
    chk("R10 x held", int'(coord_x), hx);
    chk("R10 y held", int'(coord_y), hy);

    // R9 enable dropped mid-batch
    load_vec(4);
    clear_counts();
    sample_en = 1;
    while (xtx < 3) @(negedge clk);
    sample_en = 0;
    wait_valid(ok);
    chk("R9 mid x", int'(coord_x), expect_px(xa, xb, VEC[4][4], VEC[4][5], 480));
    chk("R9 mid y", int'(coord_y), expect_px(ya, yb, VEC[4][6], VEC[4][7], 320));
    chk("R9 mid reads", xtx + ytx, 16);
    repeat (400) @(negedge clk);
    chk("R9 stop after batch", xtx + ytx, 16);
    chk("R10 one pulse", pulses, 1);

    chk("R10 width", wide_err, 0);
    chk("R3 min gap", (min_gap >= 2 * HALF * 20.0) ? 1 : 0, 1);
    chk("R1 idle sclk", int'(spi_sclk), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule